// File: doc/BRIEF.md
# Windowed Watchdog Monitor

This block watches over software that runs on the same chip. Once it is enabled, it counts ticks taken from one of four tick sources, divided by a programmable prescaler. Software proves that it is alive by writing a two-byte service key. A key counts only when it arrives while the tick counter lies between a low and a high compare value. A refresh that comes too soon, a counter that runs past the high compare, a malformed or stalled key, or an active level on an enabled external monitor pin all latch a fault. The fault stays latched until reset and can also raise an interrupt.

Software programs the compare values and the tick configuration first, then writes the control register with the enable bit set. From that point on, only the interrupt enable bit in the control register still accepts writes. Software clears a pending interrupt by writing interrupt enable back to 0. The fault output itself stays asserted.

Register map (3-bit address, 8-bit data): 0 control, 1 service key (reads 0), 2 low compare, 3 high compare, 4 tick select, 5 prescaler, 6 tick counter (read-only). Control bits: bit 0 enable, bit 1 interrupt enable, bit 2 external monitor enable, bit 3 external polarity (1 = active high).

Top module: `wdog_window_mon`

## Requirements
- R1: After reset the control, low compare, tick select, prescaler and counter read 0, the high compare reads 0xFE, and both fault and irq are 0.
- R2: While the enable bit (control bit 0) is 0, a control write loads all four bits. Once enable is 1, control writes change only interrupt enable (bit 1), and enable stays 1 until reset.
- R3: Writes to the low compare, high compare, tick select and prescaler take effect only while enable is 0. A high compare write of 0xFF is stored as 0xFE, and a write of 0 is stored as 1.
- R4: While enabled, the counter (address 6) advances by one for every (prescaler+1) rising edges of the tick source picked by the tick select field, and it ignores the other sources. It holds at 0 while disabled.
- R5: A write of 0xB4 to the service register followed by 0x2C, with the second write at most 15 clock cycles after the first, is a refresh. A refresh with the counter at or above the low compare clears the counter and raises no fault.
- R6: A refresh completed while the counter is below the low compare sets the fault.
- R7: When the counter advances past the high compare, the fault is set one cycle later.
- R8: Three key errors set the fault: a first service byte other than 0xB4, a second byte other than 0x2C, or no second byte within 15 cycles of the first.
- R9: With the external monitor enable (bit 2) set, fault rises in the same cycle that ext_mon equals the polarity bit (bit 3). With bit 2 clear, ext_mon has no effect.
- R10: Once fault is set, it stays set until reset, even after a refresh or after ext_mon returns to its idle level.
- R11: irq equals fault AND interrupt enable, so writing interrupt enable to 0 clears irq.
- R12: Service writes made while enable is 0 are ignored and set no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| tick_src | input | N_SRC | Candidate tick sources, sampled on clk |
| ext_mon | input | 1 | External monitor pin |
| fault | output | 1 | Latched fault indication |
| irq | output | 1 | Interrupt request |

## Verification
A refresh and a counter tick can land in the same clock edge. The dangerous case is a tick that would carry the counter past the high compare arriving in the same edge as the 0x2C byte. The bench provokes it by raising the selected tick source in the very cycle it drives the second key byte, with the counter sitting at the high compare. The refresh is judged against the counter value before the tick, so the expected outcome is a counter of 0 and no fault.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_CTRL = 3'd0,
        A_SERV = 3'd1,
        A_LOW  = 3'd2,
        A_HIGH = 3'd3,
        A_CSEL = 3'd4,
        A_DIV  = 3'd5,
        A_CNT  = 3'd6,
        A_NONE = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic pol;
        logic ext_en;
        logic irq_en;
        logic en;
    } ctrl_t;

    typedef enum logic {K_IDLE, K_ARMED} key_st_e;

    localparam logic [DW-1:0] KEY_A = 8'hB4;
    localparam logic [DW-1:0] KEY_B = 8'h2C;

    function automatic logic [DW-1:0] legal_high(input logic [DW-1:0] v);
        if (v == '1)       return v - 1'b1;
        else if (v == '0)  return DW'(1);
        else               return v;
    endfunction
endpackage

// File: rtl/wdm_regs.sv
module wdm_regs
    import wdm_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output ctrl_t            ctrl,
    output logic [DW-1:0]    lo,
    output logic [DW-1:0]    hi,
    output logic [SEL_W-1:0] sel,
    output logic [DW-1:0]    div
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            lo   <= '0;
            hi   <= legal_high('1);
            sel  <= '0;
            div  <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                A_CTRL: begin
                    if (!ctrl.en) ctrl        <= ctrl_t'(wdata[3:0]);
                    else          ctrl.irq_en <= wdata[1];
                end
                A_LOW:  if (!ctrl.en) lo  <= wdata;
                A_HIGH: if (!ctrl.en) hi  <= legal_high(wdata);
                A_CSEL: if (!ctrl.en) sel <= wdata[SEL_W-1:0];
                A_DIV:  if (!ctrl.en) div <= wdata;
                default: ;
            endcase
        end
    end

    a_r2_enable_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl.en |=> ctrl.en);
    a_r3_config_frozen: assert property (@(posedge clk) disable iff (rst)
        ctrl.en |=> ($stable(lo) && $stable(hi) && $stable(sel) && $stable(div)));
    a_r3_high_legal: assert property (@(posedge clk) disable iff (rst)
        (hi != '0) && (hi != '1));
endmodule

// File: rtl/wdm_tick.sv
module wdm_tick
    import wdm_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    input  logic [DW-1:0]    div,
    output logic             tick
);
    logic          src_now;
    logic          src_q;
    logic          edge_hit;
    logic [DW-1:0] pre_cnt;

    assign src_now  = src[sel];
    assign edge_hit = run && src_now && !src_q;
    assign tick     = edge_hit && (pre_cnt == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= 1'b0;
            pre_cnt <= '0;
        end else begin
            src_q <= src_now;
            if (!run)          pre_cnt <= '0;
            else if (tick)     pre_cnt <= '0;
            else if (edge_hit) pre_cnt <= pre_cnt + 1'b1;
        end
    end

    a_r4_prescale_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (pre_cnt <= div));
endmodule

// File: rtl/wdm_key.sv
module wdm_key
    import wdm_pkg::*;
#(
    parameter int GAP  = 15,
    parameter int TW   = (GAP > 1) ? $clog2(GAP) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          svc_we,
    input  logic [DW-1:0] svc_data,
    output logic          refresh,
    output logic          abort
);
    key_st_e         st;
    logic [TW-1:0]   timer;
    logic            last_slot;

    assign last_slot = (timer == TW'(GAP - 1));

    always_comb begin
        refresh = 1'b0;
        abort   = 1'b0;
        if (run) begin
            case (st)
                K_IDLE:  if (svc_we && svc_data != KEY_A) abort = 1'b1;
                K_ARMED: begin
                    if (svc_we) begin
                        if (svc_data == KEY_B) refresh = 1'b1;
                        else                   abort   = 1'b1;
                    end else if (last_slot) begin
                        abort = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st    <= K_IDLE;
            timer <= '0;
        end else begin
            case (st)
                K_IDLE: if (svc_we && svc_data == KEY_A) begin
                    st    <= K_ARMED;
                    timer <= '0;
                end
                K_ARMED: begin
                    if (svc_we || last_slot) st <= K_IDLE;
                    else                     timer <= timer + 1'b1;
                end
                default: st <= K_IDLE;
            endcase
        end
    end

    a_r8_key_window: assert property (@(posedge clk) disable iff (rst)
        (st == K_ARMED) |-> (timer < TW'(GAP)));
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(refresh && abort));
endmodule

// File: rtl/wdog_window_mon.sv
module wdog_window_mon
    import wdm_pkg::*;
#(
    parameter int N_SRC   = 4,
    parameter int KEY_GAP = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [N_SRC-1:0] tick_src,
    input  logic             ext_mon,
    output logic             fault,
    output logic             irq
);
    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    ctrl_t            ctrl;
    logic [DW-1:0]    lo, hi, div, cnt;
    logic [SEL_W-1:0] sel;
    logic             tick, refresh, abort, svc_we;
    logic             ext_hit, early, late, fault_q;

    assign svc_we = reg_we && (reg_addr_e'(reg_addr) == A_SERV);

    wdm_regs #(.SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .ctrl(ctrl), .lo(lo), .hi(hi), .sel(sel), .div(div)
    );

    wdm_tick #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst(rst), .run(ctrl.en), .src(tick_src), .sel(sel),
        .div(div), .tick(tick)
    );

    wdm_key #(.GAP(KEY_GAP)) u_key (
        .clk(clk), .rst(rst), .run(ctrl.en), .svc_we(svc_we),
        .svc_data(reg_wdata), .refresh(refresh), .abort(abort)
    );

    always_ff @(posedge clk) begin
        if (rst || !ctrl.en)         cnt <= '0;
        else if (refresh)            cnt <= '0;
        else if (tick && cnt != '1)  cnt <= cnt + 1'b1;
    end

    assign ext_hit = ctrl.en && ctrl.ext_en && (ext_mon == ctrl.pol);
    assign early   = refresh && (cnt < lo);
    assign late    = ctrl.en && (cnt > hi);

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= fault_q | abort | early | late | ext_hit;
    end

    assign fault = fault_q | ext_hit;
    assign irq   = fault & ctrl.irq_en;

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_CTRL:  reg_rdata = DW'(ctrl);
            A_LOW:   reg_rdata = lo;
            A_HIGH:  reg_rdata = hi;
            A_CSEL:  reg_rdata = DW'(sel);
            A_DIV:   reg_rdata = div;
            A_CNT:   reg_rdata = cnt;
            default: reg_rdata = '0;
        endcase
    end

    a_r10_fault_latched: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> fault_q);
    a_r5_refresh_clears: assert property (@(posedge clk) disable iff (rst)
        refresh |=> (cnt == '0));
    a_r7_late_faults: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && cnt > hi) |=> fault_q);
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt == '0 || cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> !(refresh || abort));
endmodule

// File: tb/sim_wdog_window_mon.sv
module sim_wdog_window_mon;
    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] tick_src;
    logic       ext_mon;
    logic       fault;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdog_window_mon u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_src(tick_src),
        .ext_mon(ext_mon), .fault(fault), .irq(irq)
    );

    localparam logic [2:0] CTRL = 3'd0, SERV = 3'd1, LOW = 3'd2, HIGH = 3'd3,
                           CSEL = 3'd4, DIV = 3'd5, CNT = 3'd6;

    // {requirement number, address, write data, expected readback}
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {4'd3, LOW,  8'h02, 8'h02},   // R3 pre-enable write
        {4'd3, HIGH, 8'hFF, 8'hFE},   // R3 clamp high
        {4'd3, HIGH, 8'h00, 8'h01},   // R3 clamp zero
        {4'd3, HIGH, 8'h05, 8'h05},
        {4'd3, CSEL, 8'h01, 8'h01},
        {4'd3, DIV,  8'h00, 8'h00},
        {4'd2, CTRL, 8'h03, 8'h03},   // R2 enabling write
        {4'd2, CTRL, 8'h0C, 8'h01},   // R2 only irq_en changes
        {4'd2, CTRL, 8'h03, 8'h03},
        {4'd3, LOW,  8'h09, 8'h02},   // R3 frozen
        {4'd3, HIGH, 8'h20, 8'h05},
        {4'd3, CSEL, 8'h03, 8'h01},
        {4'd3, DIV,  8'h07, 8'h00}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; tick_src = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic setup(input logic [7:0] l, input logic [7:0] h,
                         input logic [7:0] s, input logic [7:0] dv,
                         input logic [7:0] c);
        do_reset();
        wr(LOW, l); wr(HIGH, h); wr(CSEL, s); wr(DIV, dv); wr(CTRL, c);
    endtask

    task automatic pulse(input int idx);
        tick_src[idx] = 1'b1;
        @(negedge clk);
        tick_src[idx] = 1'b0;
        @(negedge clk);
    endtask

    task automatic refresh_key();
        wr(SERV, 8'hB4);
        wr(SERV, 8'h2C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v;
        ext_mon = 1'b0;
        do_reset();
        // R1 reset state
        rd(CTRL, v); check("R1 ctrl", v, 0);
        rd(HIGH, v); check("R1 high", v, 254);
        rd(CNT, v);  check("R1 count", v, 0);
        check("R1 fault", fault, 0);
        check("R1 irq", irq, 0);
        // R12 service before enable
        wr(SERV, 8'h55); wr(SERV, 8'h2C); @(negedge clk);
        check("R12 fault", fault, 0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            rd(VEC[i][18:16], v);
            n_run++;
            if (v != int'(VEC[i][7:0])) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual %0d expected %0d",
                         VEC[i][22:19], i, v, VEC[i][7:0]);
            end
        end

        // R4 selection and counting, R5 refresh, R6 early
        pulse(0); rd(CNT, v); check("R4 unselected", v, 0);
        pulse(1); pulse(1); pulse(1);
        rd(CNT, v); check("R4 count", v, 3);
        refresh_key(); @(negedge clk);
        rd(CNT, v); check("R5 cleared", v, 0);
        check("R5 no fault", fault, 0);
        refresh_key(); @(negedge clk);
        check("R6 early fault", fault, 1);
        check("R11 irq on", irq, 1);
        wr(CTRL, 8'h01); @(negedge clk);
        check("R11 irq cleared", irq, 0);
        check("R10 fault held", fault, 1);

        // R4 prescaler, R7 late, R11 interrupt enable after lock
        setup(8'h00, 8'h03, 8'h02, 8'h02, 8'h01);
        pulse(2); pulse(2);
        rd(CNT, v); check("R4 divide hold", v, 0);
        pulse(2);
        rd(CNT, v); check("R4 divide step", v, 1);
        for (int i = 0; i < 6; i++) pulse(2);
        rd(CNT, v); check("R4 at high", v, 3);
        check("R7 no fault yet", fault, 0);
        for (int i = 0; i < 3; i++) pulse(2);
        rd(CNT, v); check("R7 past high", v, 4);
        check("R7 late fault", fault, 1);
        check("R11 irq masked", irq, 0);
        wr(CTRL, 8'h03); check("R11 irq enabled", irq, 1);
        refresh_key(); @(negedge clk);
        check("R10 survives refresh", fault, 1);

        // R5 / R7 refresh and tick in the same edge
        setup(8'h00, 8'h02, 8'h00, 8'h00, 8'h01);
        pulse(0); pulse(0);
        wr(SERV, 8'hB4);
        reg_we = 1'b1; reg_addr = SERV; reg_wdata = 8'h2C; tick_src[0] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tick_src[0] = 1'b0;
        @(negedge clk);
        rd(CNT, v); check("R5 same-edge count", v, 0);
        check("R7 same-edge no fault", fault, 0);

        // R8 key errors
        setup(8'h00, 8'hFE, 8'h00, 8'h00, 8'h01);
        wr(SERV, 8'hB4); wr(SERV, 8'h11); @(negedge clk);
        check("R8 wrong second", fault, 1);
        setup(8'h00, 8'hFE, 8'h00, 8'h00, 8'h01);
        wr(SERV, 8'h2C); @(negedge clk);
        check("R8 wrong first", fault, 1);
        setup(8'h00, 8'hFE, 8'h00, 8'h00, 8'h01);
        wr(SERV, 8'hB4); repeat (14) @(negedge clk); wr(SERV, 8'h2C);
        @(negedge clk);
        check("R5 last slot", fault, 0);
        setup(8'h00, 8'hFE, 8'h00, 8'h00, 8'h01);
        wr(SERV, 8'hB4); repeat (14) @(negedge clk);
        check("R8 before timeout", fault, 0);
        @(negedge clk);
        check("R8 timeout", fault, 1);

        // R9 external monitor
        setup(8'h00, 8'hFE, 8'h00, 8'h00, 8'h0D);
        check("R9 idle high-pol", fault, 0);
        ext_mon = 1'b1; #1;
        check("R9 same cycle", fault, 1);
        @(negedge clk); ext_mon = 1'b0; @(negedge clk);
        check("R10 after pin idle", fault, 1);
        ext_mon = 1'b1;
        setup(8'h00, 8'hFE, 8'h00, 8'h00, 8'h05);
        check("R9 low-pol idle", fault, 0);
        ext_mon = 1'b0; #1;
        check("R9 low-pol hit", fault, 1);
        setup(8'h00, 8'hFE, 8'h00, 8'h00, 8'h01);
        ext_mon = 1'b1; @(negedge clk); ext_mon = 1'b0; @(negedge clk);
        check("R9 disabled", fault, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule